// File: doc/BRIEF.md
# Exception Entry State Updater

This block computes the architectural state a processor core takes on when an exception enters the first privileged level on that level's own stack pointer. A request supplies the interrupted program counter, the current status word, the vector base, the system control register, a requested target mode and an exception kind. These are sampled on one clock edge. From that same edge the block presents the handler address, the handler's status word, the saved return address and the saved copy of the old status word.

The handler address is the sum of the vector base, a group offset and a kind offset. The group offset depends on how the interrupted mode relates to the target mode. The kind offset depends on the exception class. Each bit of the new status word follows its own rule: it is inherited, cleared, forced to 1, or copied from a control bit.

A target mode other than level 1 on the handler stack is refused. The outputs keep their values and an error strobe is raised instead. The request side is a valid/ready stream with `req_ready` held high, so the block never applies back-pressure. A request is taken on every edge where `req_valid` is high, and back-to-back requests are processed one per cycle.

Top module: `exc_entry_unit`

## Requirements
- R1: The group offset is 0x200 when the current mode (status bits 4:0, where bit 4 marks 32-bit state) equals the target. It is 0x000 when the current mode with bit 0 set equals the target. Otherwise it is 0x400 when status bit 4 is 0 and 0x600 when status bit 4 is 1.
- R2: The kind offset is `req_kind` × 0x80, where 0 = synchronous, 1 = IRQ, 2 = FIQ and 3 = SError.
- R3: `new_pc` equals `vec_base` + group offset + kind offset.
- R4: `link_addr` receives the request's `cur_pc`, and `saved_status` receives the complete `cur_status`.
- R5: New status bits 31..28 (N, Z, C, V) and bit 24 (data-independent timing) are copied from the old status.
- R6: New status bit 22 (privileged-access-never) equals old bit 22 OR'd with the inverse of `sys_ctrl` bit 23.
- R7: New status bit 12 (store-bypass-safe) equals `sys_ctrl` bit 44.
- R8: Every new status bit not named in R5, R6, R7 or R9 is 0. This includes bit 23 (user access override), bit 21 (single step), bit 20 (illegal state) and bits 11:10 (branch type).
- R9: New status bits 9..6 (D, A, I, F) are 1, and bits 4:0 hold the target mode 0b00101.
- R10: A request whose `req_target` is not 0b00101 leaves all four state outputs unchanged. It raises `err` for exactly one cycle and does not raise `done`.
- R11: A request accepted on one edge has its results on the outputs after that edge, with `done` high for that one cycle only. `req_ready` is always 1, and consecutive requests are each completed in turn.
- R12: While reset is asserted, all state outputs are 0 and `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Always 1; no back-pressure |
| req_target | input | 5 | Requested target mode code |
| req_kind | input | 2 | Exception class |
| cur_pc | input | ADDR_W (64) | Interrupted program counter |
| cur_status | input | STAT_W (32) | Current status word |
| vec_base | input | ADDR_W (64) | Vector base address |
| sys_ctrl | input | CTRL_W (64) | System control register |
| new_pc | output | ADDR_W (64) | Handler address |
| new_status | output | STAT_W (32) | Handler status word |
| link_addr | output | ADDR_W (64) | Saved return address |
| saved_status | output | STAT_W (32) | Saved old status word |
| done | output | 1 | One-cycle pulse when an entry completes |
| err | output | 1 | One-cycle pulse when a target is refused |

## Verification
The embedded assertions check the following on every cycle:
- `done` and `err` are never high together.
- Each completed entry carries the masked interrupt bits and the fixed target mode.
- The saved return address and saved status match the request inputs of the previous cycle.
- A refused target leaves all four state outputs stable.

The handler address arithmetic and the per-bit inherit, clear and force rules depend on the data. They are shown only by the bench's sweep over all 32 current-mode codes and all four exception kinds, with random status and control words. The same holds for the target-rejection sweep and the back-to-back case.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    KIND_SYNC = 2'd0,
    KIND_IRQ  = 2'd1,
    KIND_FIQ  = 2'd2,
    KIND_SERR = 2'd3
  } exc_kind_e;

  localparam int MODE_W       = 5;
  localparam int MODE_32_BIT  = 4;
  localparam logic [MODE_W-1:0] MODE_L1_HANDLER = 5'b00101;
  localparam logic [MODE_W-1:0] STACK_SEL_MASK  = 5'b00001;

  localparam int ST_FLAG_HI = 31;
  localparam int ST_FLAG_LO = 28;
  localparam int ST_DIT     = 24;
  localparam int ST_PAN     = 22;
  localparam int ST_SSBS    = 12;
  localparam int ST_MASK_HI = 9;
  localparam int ST_MASK_LO = 6;

  localparam int CTL_SPAN  = 23;
  localparam int CTL_DSSBS = 44;

  localparam int OFS_W      = 11;
  localparam int KIND_SHIFT = 7;
  localparam logic [OFS_W-1:0] GRP_SAME_HANDLER = 11'h200;
  localparam logic [OFS_W-1:0] GRP_SAME_THREAD  = 11'h000;
  localparam logic [OFS_W-1:0] GRP_LOWER_64     = 11'h400;
  localparam logic [OFS_W-1:0] GRP_LOWER_32     = 11'h600;
endpackage

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] target,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] vec_pc
);
  logic [OFS_W-1:0] grp_off;
  logic [OFS_W-1:0] kind_off;

  always_comb begin
    if (cur_mode == target)
      grp_off = GRP_SAME_HANDLER;
    else if ((cur_mode | STACK_SEL_MASK) == target)
      grp_off = GRP_SAME_THREAD;
    else if (!cur_mode[MODE_32_BIT])
      grp_off = GRP_LOWER_64;
    else
      grp_off = GRP_LOWER_32;
  end

  assign kind_off = OFS_W'(kind) << KIND_SHIFT;
  assign vec_pc   = base + ADDR_W'(grp_off) + ADDR_W'(kind_off);
endmodule

// File: rtl/exc_status_build.sv
module exc_status_build
  import exc_entry_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int CTRL_W = 64
) (
  input  logic [STAT_W-1:0] old_status,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [MODE_W-1:0] target,
  output logic [STAT_W-1:0] next_status
);
  localparam int NUM_KEEP = 5;
  localparam int KEEP_POS [NUM_KEEP] = '{ST_FLAG_HI, ST_FLAG_HI-1, ST_FLAG_HI-2, ST_FLAG_LO, ST_DIT};

  logic [STAT_W-1:0] kept;

  generate
    for (genvar g = 0; g < STAT_W; g++) begin : g_keep
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NUM_KEEP; k++)
          if (KEEP_POS[k] == g) hit = 1'b1;
      end
      assign kept[g] = hit & old_status[g];
    end
  endgenerate

  always_comb begin
    next_status = kept;
    next_status[ST_PAN]  = old_status[ST_PAN] | ~ctrl[CTL_SPAN];
    next_status[ST_SSBS] = ctrl[CTL_DSSBS];
    next_status[ST_MASK_HI:ST_MASK_LO] = '1;
    next_status[MODE_W-1:0] = target;
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int STAT_W = 32,
  parameter int CTRL_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [4:0]        req_target,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [STAT_W-1:0] cur_status,
  input  logic [ADDR_W-1:0] vec_base,
  input  logic [CTRL_W-1:0] sys_ctrl,
  output logic [ADDR_W-1:0] new_pc,
  output logic [STAT_W-1:0] new_status,
  output logic [ADDR_W-1:0] link_addr,
  output logic [STAT_W-1:0] saved_status,
  output logic              done,
  output logic              err
);
  logic [ADDR_W-1:0] vec_pc_c;
  logic [STAT_W-1:0] status_c;
  logic              target_ok;

  assign req_ready = 1'b1;
  assign target_ok = (req_target == MODE_L1_HANDLER);

  exc_vector_calc #(.ADDR_W(ADDR_W)) vec_i (
    .cur_mode (cur_status[MODE_W-1:0]),
    .target   (req_target),
    .kind     (req_kind),
    .base     (vec_base),
    .vec_pc   (vec_pc_c)
  );

  exc_status_build #(.STAT_W(STAT_W), .CTRL_W(CTRL_W)) stat_i (
    .old_status  (cur_status),
    .ctrl        (sys_ctrl),
    .target      (req_target),
    .next_status (status_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_pc       <= '0;
      new_status   <= '0;
      link_addr    <= '0;
      saved_status <= '0;
      done         <= 1'b0;
      err          <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (req_valid) begin
        if (target_ok) begin
          new_pc       <= vec_pc_c;
          new_status   <= status_c;
          link_addr    <= cur_pc;
          saved_status <= cur_status;
          done         <= 1'b1;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  // R10 R11
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));

  // R9
  mask_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_status[ST_MASK_HI:ST_MASK_LO] == 4'hF && new_status[MODE_W-1:0] == MODE_L1_HANDLER));

  // R4
  link_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (link_addr == $past(cur_pc) && saved_status == $past(cur_status)));

  // R10
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(new_pc) && $stable(new_status) && $stable(link_addr) && $stable(saved_status)));

  // R11
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && target_ok) |=> done);
endmodule

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_target = 5'd5;
  logic [1:0]  req_kind = 2'd0;
  logic [63:0] cur_pc = '0;
  logic [31:0] cur_status = '0;
  logic [63:0] vec_base = '0;
  logic [63:0] sys_ctrl = '0;
  logic [63:0] new_pc;
  logic [31:0] new_status;
  logic [63:0] link_addr;
  logic [31:0] saved_status;
  logic        done;
  logic        err;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #5 clk = ~clk;

  exc_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_target(req_target), .req_kind(req_kind), .cur_pc(cur_pc),
    .cur_status(cur_status), .vec_base(vec_base), .sys_ctrl(sys_ctrl),
    .new_pc(new_pc), .new_status(new_status), .link_addr(link_addr),
    .saved_status(saved_status), .done(done), .err(err)
  );

  function automatic logic [63:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic logic [63:0] exp_pc(logic [31:0] st, logic [63:0] base, logic [1:0] kind);
    logic [4:0] m;
    logic [63:0] grp;
    m = st[4:0];
    if (m == 5'd5) grp = 64'h200;
    else if ((m | 5'd1) == 5'd5) grp = 64'h000;
    else if (!m[4]) grp = 64'h400;
    else grp = 64'h600;
    return base + grp + 64'(kind) * 64'h80;
  endfunction

  function automatic logic [31:0] exp_status(logic [31:0] st, logic [63:0] ctl);
    logic [31:0] n;
    n = '0;
    n[31:28] = st[31:28];
    n[24] = st[24];
    n[22] = st[22] | ~ctl[23];
    n[12] = ctl[44];
    n[9:6] = 4'hF;
    n[4:0] = 5'b00101;
    return n;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] pc, input logic [31:0] st, input logic [63:0] base,
                       input logic [63:0] ctl, input logic [4:0] tgt, input logic [1:0] kind);
    cur_pc = pc; cur_status = st; vec_base = base; sys_ctrl = ctl;
    req_target = tgt; req_kind = kind; req_valid = 1'b1;
  endtask

  task automatic check_out(input logic [63:0] pc, input logic [31:0] st, input logic [63:0] base,
                           input logic [63:0] ctl, input logic [1:0] kind);
    logic [31:0] es;
    logic [31:0] other;
    es = exp_status(st, ctl);
    other = 32'hFFFF_FFFF;
    other[31:28] = 4'h0; other[24] = 1'b0; other[22] = 1'b0; other[12] = 1'b0;
    other[9:6] = 4'h0; other[4:0] = 5'h0;
    chk("R11 done", 64'(done), 64'd1);
    chk("R1 R2 R3 new_pc", new_pc, exp_pc(st, base, kind));
    chk("R4 link_addr", link_addr, pc);
    chk("R4 saved_status", 64'(saved_status), 64'(st));
    chk("R5 flags and dit", 64'({new_status[31:28], new_status[24]}), 64'({es[31:28], es[24]}));
    chk("R6 pan", 64'(new_status[22]), 64'(es[22]));
    chk("R7 ssbs", 64'(new_status[12]), 64'(es[12]));
    chk("R8 cleared bits", 64'(new_status & other), 64'd0);
    chk("R9 masks and mode", 64'({new_status[9:6], new_status[4:0]}), 64'({4'hF, 5'b00101}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] pc, base, ctl, r;
    logic [31:0] st;
    logic [63:0] pc_b, base_b, ctl_b;
    logic [31:0] st_b;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 new_pc", new_pc, 64'd0);
    chk("R12 status", 64'({new_status, saved_status}), 64'd0);
    chk("R12 link", link_addr, 64'd0);
    chk("R12 pulses", 64'({done, err}), 64'd0);
    chk("R11 ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep all current-mode codes and kinds (R1..R9, R11)
    for (int m = 0; m < 32; m++) begin
      for (int k = 0; k < 4; k++) begin
        r = next_rand(); st = {r[31:5], 5'(m)};
        pc = next_rand(); base = next_rand(); ctl = next_rand();
        drive(pc, st, base, ctl, 5'd5, 2'(k));
        @(negedge clk);
        req_valid = 1'b0;
        check_out(pc, st, base, ctl, 2'(k));
        chk("R11 ready", 64'(req_ready), 64'd1);
        @(negedge clk);
        chk("R11 done one cycle", 64'({done, err}), 64'd0);
      end
    end

    // Back-to-back requests (R11)
    r = next_rand(); st = {r[31:5], 5'd4}; pc = next_rand(); base = next_rand(); ctl = next_rand();
    r = next_rand(); st_b = {r[31:5], 5'd16}; pc_b = next_rand(); base_b = next_rand(); ctl_b = next_rand();
    drive(pc, st, base, ctl, 5'd5, 2'd1);
    @(negedge clk);
    drive(pc_b, st_b, base_b, ctl_b, 5'd5, 2'd3);
    check_out(pc, st, base, ctl, 2'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check_out(pc_b, st_b, base_b, ctl_b, 2'd3);
    @(negedge clk);
    chk("R11 back-to-back end", 64'(done), 64'd0);

    // Refused targets (R10)
    for (int t = 0; t < 32; t++) begin
      if (t != 5) begin
        r = next_rand(); st = {r[31:5], 5'd0}; pc = next_rand(); base = next_rand(); ctl = next_rand();
        drive(pc, st, base, ctl, 5'd5, 2'd2);
        @(negedge clk);
        drive(~pc, ~st, ~base, ~ctl, 5'(t), 2'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 err high", 64'({err, done}), 64'b10);
        chk("R10 pc held", new_pc, exp_pc(st, base, 2'd2));
        chk("R10 status held", 64'(new_status), 64'(exp_status(st, ctl)));
        chk("R10 link held", link_addr, pc);
        chk("R10 saved held", 64'(saved_status), 64'(st));
        @(negedge clk);
        chk("R10 err one cycle", 64'(err), 64'd0);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule